// File: doc/BRIEF.md
# Peripheral Request Line to DMA Channel Mapper

This block sits between a set of peripheral request lines and the channel engines of a DMA controller. For each request line it holds a small programmable mapping entry. The entry has a valid flag and the number of the channel that should serve the line. Each channel receives a request output. That output is asserted whenever any line with a valid entry that names that channel is itself asserted.

Software programs the entries through a simple register port: a write strobe, an address and write data, plus read data that follows the address in the same cycle. There are more request lines than fit in one address window, so the entries are split across two windows. The first window holds the first 64 lines. The second window holds every line from 64 upward. The router is purely combinational from the request lines to the channel outputs. A new mapping takes effect in the cycle after the clock edge that wrote it.

Top module: `dreq_chan_mapper`

## Requirements
- R1: After reset every mapping entry is cleared. All entries read as zero, and no channel request is raised whatever the request lines do.
- R2: The entry of line n, for n below 64, is written at byte address 0x100 + 4*n. The write stores data bit 7 as the valid flag and data bits 4:0 as the channel number.
- R3: The entry of line n, for n of 64 or more, is written at byte address 0x1100 + 4*(n-64), using the same field positions as R2.
- R4: A line whose valid flag is clear drives no channel request, whatever channel number its entry holds.
- R5: Channel output c equals the OR of all asserted request lines whose entry is valid and names channel c. It follows the request lines in the same cycle.
- R6: When several valid lines name the same channel, any one of them alone raises that channel's request.
- R7: A read at a line's address returns the valid flag in bit 7 and the channel number in bits 4:0, with all other bits zero. A read at any address that selects no line returns zero.
- R8: A write is ignored if its address lies outside both windows, is not a multiple of four, or lies past the last implemented line. Every stored entry keeps its value.
- R9: A channel request reflects a new mapping from the clock cycle after the write edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the entry selected by reg_addr |
| periph_req | input | NUM_LINES | Peripheral request lines |
| chan_req | output | NUM_CHAN | Per-channel request outputs |

## Verification
A corrupted entry appears in two places at once. A read of that line returns the wrong value, and asserting only that line raises the wrong channel bit, or none, or an extra one. Both are visible in the cycle after the faulty write. A wrong window decode shows up as a neighbouring line being overwritten, which the full read-back after each write sweep exposes. A fault in the OR network appears only when two lines share a channel, so the shared-channel cases are driven both one line at a time and together.

// File: rtl/dreq_map_pkg.sv
package dreq_map_pkg;
  localparam int CHAN_FIELD_W = 5;
  localparam int VALID_BIT    = 7;
  localparam int LO_BASE      = 'h100;
  localparam int HI_BASE      = 'h1100;
  localparam int WIN_LINES    = 64;

  typedef struct packed {
    logic                    valid;
    logic [CHAN_FIELD_W-1:0] chan;
  } map_entry_t;
endpackage

// File: rtl/dreq_map_decode.sv
module dreq_map_decode
  import dreq_map_pkg::*;
#(
  parameter int NUM_LINES = 72,
  parameter int ADDR_W    = 16,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  localparam int LO_LINES = (NUM_LINES < WIN_LINES) ? NUM_LINES : WIN_LINES;
  localparam int HI_LINES = NUM_LINES - LO_LINES;
  localparam logic [ADDR_W-1:0] LO_START = ADDR_W'(LO_BASE);
  localparam logic [ADDR_W-1:0] LO_END   = ADDR_W'(LO_BASE + 4 * LO_LINES);
  localparam logic [ADDR_W-1:0] HI_START = ADDR_W'(HI_BASE);
  localparam logic [ADDR_W-1:0] HI_END   = ADDR_W'(HI_BASE + 4 * HI_LINES);

  logic              aligned;
  logic              lo_hit;
  logic              hi_hit;
  logic [ADDR_W-1:0] lo_off;
  logic [ADDR_W-1:0] hi_off;

  always_comb begin
    aligned = (addr[1:0] == 2'b00);
    lo_off  = addr - LO_START;
    hi_off  = addr - HI_START;
    lo_hit  = aligned && (addr >= LO_START) && (addr < LO_END);
    hi_hit  = aligned && (HI_LINES > 0) && (addr >= HI_START) && (addr < HI_END);
    hit     = lo_hit || hi_hit;
    if (hi_hit) begin
      idx = IDX_W'(hi_off >> 2) + IDX_W'(WIN_LINES);
    end else begin
      idx = IDX_W'(lo_off >> 2);
    end
  end
endmodule

// File: rtl/dreq_map_bank.sv
module dreq_map_bank
  import dreq_map_pkg::*;
#(
  parameter int NUM_LINES = 72,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  map_entry_t                   wr_entry,
  output map_entry_t [NUM_LINES-1:0]   map_q
);
  map_entry_t [NUM_LINES-1:0] map_d;
  logic       [NUM_LINES-1:0] line_en;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    assign line_en[l] = wr_en && (wr_idx == IDX_W'(l));

    always_comb begin
      map_d[l] = map_q[l];
      if (line_en[l]) begin
        map_d[l] = wr_entry;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        map_q[l] <= '0;
      end else if (line_en[l]) begin
        map_q[l] <= map_d[l];
      end
    end
  end
endmodule

// File: rtl/dreq_req_router.sv
module dreq_req_router
  import dreq_map_pkg::*;
#(
  parameter int NUM_LINES = 72,
  parameter int NUM_CHAN  = 32
) (
  input  map_entry_t [NUM_LINES-1:0] map_q,
  input  logic [NUM_LINES-1:0]       periph_req,
  output logic [NUM_CHAN-1:0]        chan_req
);
  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    always_comb begin
      chan_req[c] = 1'b0;
      for (int l = 0; l < NUM_LINES; l++) begin
        if (periph_req[l] && map_q[l].valid &&
            (map_q[l].chan == CHAN_FIELD_W'(c))) begin
          chan_req[c] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dreq_chan_mapper.sv
module dreq_chan_mapper
  import dreq_map_pkg::*;
#(
  parameter int NUM_LINES = 72,
  parameter int NUM_CHAN  = 32,
  parameter int ADDR_W    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NUM_LINES-1:0] periph_req,
  output logic [NUM_CHAN-1:0]  chan_req
);
  localparam int IDX_W = $clog2(NUM_LINES);

  logic [1:0]                 rst_pipe_q;
  logic [1:0]                 rst_pipe_d;
  logic                       rst_sync_n;
  logic                       addr_hit;
  logic [IDX_W-1:0]           addr_idx;
  logic                       wr_en;
  map_entry_t                 wr_entry;
  map_entry_t [NUM_LINES-1:0] map_q;
  map_entry_t                 rd_entry;

  assign rst_pipe_d = {rst_pipe_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= rst_pipe_d;
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

  dreq_map_decode #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_decode (
    .addr (reg_addr),
    .hit  (addr_hit),
    .idx  (addr_idx)
  );

  always_comb begin
    wr_en          = reg_wr && addr_hit;
    wr_entry.valid = reg_wdata[VALID_BIT];
    wr_entry.chan  = reg_wdata[CHAN_FIELD_W-1:0];
  end

  dreq_map_bank #(.NUM_LINES(NUM_LINES)) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_idx   (addr_idx),
    .wr_entry (wr_entry),
    .map_q    (map_q)
  );

  always_comb begin
    rd_entry  = addr_hit ? map_q[addr_idx] : '0;
    reg_rdata = '0;
    reg_rdata[VALID_BIT]          = rd_entry.valid;
    reg_rdata[CHAN_FIELD_W-1:0]   = rd_entry.chan;
  end

  dreq_req_router #(.NUM_LINES(NUM_LINES), .NUM_CHAN(NUM_CHAN)) u_router (
    .map_q      (map_q),
    .periph_req (periph_req),
    .chan_req   (chan_req)
  );
endmodule

// File: rtl/dreq_chan_mapper_chk.sv
module dreq_chan_mapper_chk
  import dreq_map_pkg::*;
#(
  parameter int NUM_LINES = 72,
  parameter int NUM_CHAN  = 32,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       reg_wr,
  input logic                       wr_hit,
  input logic [IDX_W-1:0]           wr_idx,
  input logic [31:0]                reg_wdata,
  input logic [31:0]                reg_rdata,
  input map_entry_t [NUM_LINES-1:0] map_q,
  input logic [NUM_LINES-1:0]       periph_req,
  input logic [NUM_CHAN-1:0]        chan_req
);
  // R7: only the valid flag and channel field may read as nonzero
  assert_rdata_unused_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[31:8] == '0) && (reg_rdata[6:5] == '0));

  // R5: with no request line asserted no channel request may appear
  assert_idle_no_chan_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_req == '0) |-> (chan_req == '0));

  // R2: a decoded write lands in the selected entry on the next edge
  assert_write_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && wr_hit) |=>
      (map_q[$past(wr_idx)] == map_entry_t'({$past(reg_wdata[7]), $past(reg_wdata[4:0])})));

  // R8: without a decoded write no entry changes
  assert_no_stray_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && wr_hit) |=> $stable(map_q));
endmodule

bind dreq_chan_mapper dreq_chan_mapper_chk #(
  .NUM_LINES (NUM_LINES),
  .NUM_CHAN  (NUM_CHAN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .reg_wr     (reg_wr),
  .wr_hit     (addr_hit),
  .wr_idx     (addr_idx),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .map_q      (map_q),
  .periph_req (periph_req),
  .chan_req   (chan_req)
);

// File: tb/dreq_chan_mapper_test.sv
module dreq_chan_mapper_test;
  localparam int NL = 72;
  localparam int NC = 32;
  localparam int AW = 16;

  logic          clk;
  logic          rst_n;
  logic          reg_wr;
  logic [AW-1:0] reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic [NL-1:0] periph_req;
  logic [NC-1:0] chan_req;

  int n_total;
  int n_fail;

  dreq_chan_mapper #(.NUM_LINES(NL), .NUM_CHAN(NC), .ADDR_W(AW)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .periph_req (periph_req),
    .chan_req   (chan_req)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [AW-1:0] line_addr(input int l);
    if (l < 64) return AW'(32'h100 + 4 * l);
    return AW'(32'h1100 + 4 * (l - 64));
  endfunction

  function automatic int map_of(input int l);
    return (l * 7 + 3) % 32;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic drive(input logic [NL-1:0] r, output logic [NC-1:0] c);
    @(negedge clk);
    periph_req = r;
    #1;
    c = chan_req;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [31:0]   d;
    logic [NC-1:0] c;
    logic [NC-1:0] exp_c;
    n_total    = 0;
    n_fail     = 0;
    rst_n      = 1'b0;
    reg_wr     = 1'b0;
    reg_addr   = '0;
    reg_wdata  = '0;
    periph_req = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    for (int l = 0; l < NL; l++) begin
      rd(line_addr(l), d);
      check("R1 reset read", 64'(d), 64'h0);
    end
    drive('1, c);
    check("R1 reset no request", 64'(c), 64'h0);
    drive('0, c);

    // R2 R3: program every line, valid, with extra junk in unused bits
    for (int l = 0; l < NL; l++)
      wr(line_addr(l), 32'hFFFF_FF60 | 32'h80 | 32'(map_of(l)));
    for (int l = 0; l < NL; l++) begin
      rd(line_addr(l), d);
      check(l < 64 ? "R2 R7 readback lo" : "R3 R7 readback hi", 64'(d),
            64'(32'h80 | 32'(map_of(l))));
    end

    // R5: each line alone raises exactly its channel
    for (int l = 0; l < NL; l++) begin
      logic [NL-1:0] r;
      r = '0;
      r[l] = 1'b1;
      drive(r, c);
      check("R5 single line route", 64'(c), 64'(1) << map_of(l));
    end

    // R5: patterned multi-line request, expected OR computed here
    for (int p = 0; p < 4; p++) begin
      logic [NL-1:0] r;
      exp_c = '0;
      for (int l = 0; l < NL; l++) begin
        r[l] = ((l * (p + 3)) % 5) == p;
        if (r[l]) exp_c[map_of(l)] = 1'b1;
      end
      drive(r, c);
      check("R5 pattern OR", 64'(c), 64'(exp_c));
    end
    drive('0, c);

    // R7: unaligned and unmapped reads give zero
    rd(AW'(16'h101), d);  check("R7 unaligned read", 64'(d), 64'h0);
    rd(AW'(16'h200), d);  check("R7 gap read", 64'(d), 64'h0);
    rd(AW'(16'h1120), d); check("R7 past last read", 64'(d), 64'h0);

    // R8: ignored writes leave every entry intact
    wr(AW'(16'h0FC), 32'h9F);
    wr(AW'(16'h200), 32'h9F);
    wr(AW'(16'h1120), 32'h9F);
    wr(AW'(16'h102), 32'h9F);
    wr(AW'(16'h1101), 32'h9F);
    for (int l = 0; l < NL; l++) begin
      rd(line_addr(l), d);
      check("R8 stray writes ignored", 64'(d), 64'(32'h80 | 32'(map_of(l))));
    end

    // R6: lines 5 (lo) and 70 (hi) both on channel 9
    wr(line_addr(5), 32'h89);
    wr(line_addr(70), 32'h89);
    begin
      logic [NL-1:0] r;
      r = '0; r[5] = 1'b1;  drive(r, c); check("R6 shared lo alone", 64'(c), 64'(32'h200));
      r = '0; r[70] = 1'b1; drive(r, c); check("R6 shared hi alone", 64'(c), 64'(32'h200));
      r = '0; r[5] = 1'b1; r[70] = 1'b1;
      drive(r, c); check("R6 shared both", 64'(c), 64'(32'h200));

      // R4: clear valid of line 5, keep channel field
      wr(line_addr(5), 32'h09);
      rd(line_addr(5), d); check("R4 invalid readback", 64'(d), 64'h09);
      r = '0; r[5] = 1'b1;  drive(r, c); check("R4 invalid not routed", 64'(c), 64'h0);
      r[70] = 1'b1;         drive(r, c); check("R4 other line still routed", 64'(c), 64'(32'h200));

      // R9: remap line 70 to channel 31, seen right after the write edge
      @(negedge clk);
      periph_req = '0;
      periph_req[70] = 1'b1;
      reg_addr  = line_addr(70);
      reg_wdata = 32'h9F;
      reg_wr    = 1'b1;
      #1;
      check("R9 old mapping before edge", 64'(chan_req), 64'(32'h200));
      @(negedge clk);
      reg_wr = 1'b0;
      #1;
      check("R9 new mapping after edge", 64'(chan_req), 64'(32'h8000_0000));
    end
    drive('0, c);

    summary();
  end
endmodule